// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Controller

This block produces the vertical scanline count for a display pipe that can stretch its vertical blank. A one-cycle `line_tick` input stands in for horizontal timing, and each tick advances the line counter by one. When variable refresh is not live, the frame has a fixed vertical total. The shadow-register latch strobe fires at a fixed vblank-start line.

When variable refresh is live, the frame is stretched until software sends a push or the maximum decision boundary is reached. A push is a `push_wr` pulse while `push_en` is high. The block then runs a vblank-exit window whose length is the guardband. The latch strobe fires on the first line of that window, and the frame wraps to line 0 with a frame-start pulse when the window ends. `push_pending` reads back an accepted push until the frame logic consumes it. `live_en` reports the variable-refresh state of the current frame.

The block has no data stream, so all pins are plain control and status with no back-pressure. Programmed totals use a minus-one encoding: the block adds one to get the real line count. Configuration inputs are expected to stay still within a frame.

Top module: `vrr_vtiming`

## Requirements
- R1: `vmin_m1`, `vmax_m1` and `flip_m1` hold a line total minus one. The block uses the field value plus one as the total, so with no push a live frame lasts `vmax_m1`+1 lines when `ign_max_shift` is 1.
- R2: While `live_en` is 0, a frame lasts `fix_vtotal` lines, and `latch_strobe` pulses in the cycle `line_cnt` becomes `fix_vblank_start`.
- R3: While `live_en` is 1 and no push is pending, the exit window starts at line (`vmax_m1`+1−`guard`). The strobe pulses there and the frame lasts `vmax_m1`+1 lines.
- R4: A push pending while line N lies at or after the earliest boundary starts the exit window at line N+1. The strobe pulses there and the frame lasts N+1+`guard` lines.
- R5: A push taken before the earliest boundary (`flip_m1`+1−`guard`) is held and starts the window exactly at that boundary. Any number of pushes before it count as one, and nothing carries into the next frame.
- R6: `push_wr` is accepted only when `push_en` is 1 and `live_en` is 1; otherwise it leaves `push_pending` at 0.
- R7: `push_pending` goes to 1 in the cycle after an accepted push. It stays 1 until the exit window starts, then clears by itself.
- R8: Changes of `ctl_enable` take effect only at a frame wrap, and `live_en` changes only in the cycle `frame_start` pulses. Clearing the enable lets the current stretched frame finish unchanged.
- R9: With `flip_en` at 0, the earliest boundary is (`vmin_m1`+2−`guard`) instead of the flip-line value.
- R10: With `ign_max_shift` at 0, the no-push exit window starts at line `vmax_m1`+1, and the frame lasts `vmax_m1`+1+`guard` lines.
- R11: `frame_start` pulses for one cycle, in the cycle `line_cnt` returns to 0.
- R12: After reset, `line_cnt` is 0 and `live_en`, `push_pending`, `frame_start` and `latch_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_tick | input | 1 | One-cycle pulse per scanline |
| fix_vtotal | input | LINE_W | Fixed-mode vertical total (real count) |
| fix_vblank_start | input | LINE_W | Fixed-mode latch line |
| vmin_m1 | input | LINE_W | Minimum total minus one |
| vmax_m1 | input | LINE_W | Maximum total minus one |
| flip_m1 | input | LINE_W | Flip-line total minus one |
| guard | input | GUARD_W | Vblank-exit length in lines (at least 1) |
| ctl_enable | input | 1 | Requested variable refresh enable |
| ign_max_shift | input | 1 | 1: maximum boundary is pulled in by the guardband |
| flip_en | input | 1 | 1: earliest boundary uses the flip line |
| push_en | input | 1 | Push arming bit |
| push_wr | input | 1 | Push-send write pulse |
| line_cnt | output | LINE_W | Current scanline |
| frame_start | output | 1 | Frame-start pulse |
| latch_strobe | output | 1 | Shadow-register latch pulse |
| live_en | output | 1 | Variable refresh live for this frame |
| push_pending | output | 1 | Push accepted and not yet consumed |

## Verification
The bench builds the block with its default widths: 16-bit line counters and an 8-bit guardband. It programs small totals, with a fixed total of 20, vblank start 12, flip line 21, maximum 40 and guardband 4, so each frame runs a few dozen ticks. These values put the earliest boundary at line 17 and the latest at line 36. That spread lets early, in-window, last-line and absent pushes be checked against exact frame lengths. A second minimum value moves the earliest boundary to line 15, which separates the flip-line path from the minimum-total path.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
  typedef enum logic {
    PH_SCAN = 1'b0,
    PH_EXIT = 1'b1
  } vrr_phase_e;
endpackage

// File: rtl/vrr_bounds.sv
module vrr_bounds #(
  parameter int LINE_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic [LINE_W-1:0]  vmin_m1,
  input  logic [LINE_W-1:0]  vmax_m1,
  input  logic [LINE_W-1:0]  flip_m1,
  input  logic [GUARD_W-1:0] guard,
  input  logic               flip_en,
  input  logic               ign_max_shift,
  output logic [LINE_W-1:0]  early_line,
  output logic [LINE_W-1:0]  late_line
);
  localparam logic [LINE_W-1:0] ONE = LINE_W'(1);
  localparam logic [LINE_W-1:0] TWO = LINE_W'(2);

  logic [LINE_W-1:0] guard_ext;
  logic [LINE_W-1:0] min_gate;
  logic [LINE_W-1:0] vmax_real;

  always_comb begin
    guard_ext  = LINE_W'(guard);
    // shortest blank: flip line, or the minimum total plus one when the flip line is off
    min_gate   = flip_en ? (flip_m1 + ONE) : (vmin_m1 + TWO);
    vmax_real  = vmax_m1 + ONE;
    early_line = min_gate - guard_ext;
    late_line  = ign_max_shift ? (vmax_real - guard_ext) : vmax_real;
  end
endmodule

// File: rtl/vrr_push_ctl.sv
module vrr_push_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic push_wr,
  input  logic push_en,
  input  logic live_en,
  input  logic consume,
  output logic pend_q
);
  logic accept;

  always_comb accept = push_wr & push_en & live_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q & ~consume) | accept;
  end

  // R7: a consumed push clears unless a new one lands in the same cycle
  a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && consume && !push_wr) |=> !pend_q);

  // R6: an unarmed push never raises the pending flag
  a_r6_unarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && push_wr && !push_en) |=> !pend_q);

  // R6: no push is taken while variable refresh is not live
  a_r6_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !live_en) |=> !pend_q);
endmodule

// File: rtl/vrr_line_fsm.sv
module vrr_line_fsm
  import vrr_pkg::*;
#(
  parameter int LINE_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_tick,
  input  logic               ctl_enable,
  input  logic [LINE_W-1:0]  fix_vtotal,
  input  logic [LINE_W-1:0]  fix_vblank_start,
  input  logic [LINE_W-1:0]  early_line,
  input  logic [LINE_W-1:0]  late_line,
  input  logic [GUARD_W-1:0] guard,
  input  logic               pend,
  output logic               consume,
  output logic [LINE_W-1:0]  line_q,
  output logic               frame_start_q,
  output logic               latch_q,
  output logic               live_q
);
  localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

  vrr_phase_e        phase_q;
  logic [LINE_W-1:0] exit_end_q;
  logic [LINE_W-1:0] nxt;
  logic              wrap;
  logic              go_exit;

  always_comb begin
    nxt     = line_q + ONE;
    wrap    = live_q ? (phase_q == PH_EXIT && nxt == exit_end_q)
                     : (nxt == fix_vtotal);
    go_exit = live_q && phase_q == PH_SCAN &&
              ((pend && nxt >= early_line) || nxt >= late_line);
    consume = line_tick && go_exit && pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q        <= '0;
      phase_q       <= PH_SCAN;
      exit_end_q    <= '0;
      frame_start_q <= 1'b0;
      latch_q       <= 1'b0;
      live_q        <= 1'b0;
    end else begin
      frame_start_q <= 1'b0;
      latch_q       <= 1'b0;
      if (line_tick) begin
        if (wrap) begin
          line_q        <= '0;
          phase_q       <= PH_SCAN;
          frame_start_q <= 1'b1;
          live_q        <= ctl_enable;
        end else begin
          line_q <= nxt;
          if (!live_q) begin
            latch_q <= (nxt == fix_vblank_start);
          end else if (go_exit) begin
            phase_q    <= PH_EXIT;
            exit_end_q <= nxt + LINE_W'(guard);
            latch_q    <= 1'b1;
          end
        end
      end
    end
  end

  // R8: the live status moves only together with a frame start
  a_r8_live_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q != $past(live_q)) |-> frame_start_q);

  // R4: a stretched-frame latch lies between the decision boundaries
  a_r4_latch_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && live_q) |-> (line_q >= early_line && line_q <= late_line));

  // R2: a fixed-frame latch is at the fixed vblank start
  a_r2_fixed_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !live_q) |-> (line_q == fix_vblank_start));

  // R11: a frame start is never coincident with a latch
  a_r11_start_alone: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_q |-> !latch_q);
endmodule

// File: rtl/vrr_vtiming.sv
module vrr_vtiming #(
  parameter int LINE_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_tick,
  input  logic [LINE_W-1:0]  fix_vtotal,
  input  logic [LINE_W-1:0]  fix_vblank_start,
  input  logic [LINE_W-1:0]  vmin_m1,
  input  logic [LINE_W-1:0]  vmax_m1,
  input  logic [LINE_W-1:0]  flip_m1,
  input  logic [GUARD_W-1:0] guard,
  input  logic               ctl_enable,
  input  logic               ign_max_shift,
  input  logic               flip_en,
  input  logic               push_en,
  input  logic               push_wr,
  output logic [LINE_W-1:0]  line_cnt,
  output logic               frame_start,
  output logic               latch_strobe,
  output logic               live_en,
  output logic               push_pending
);
  logic [LINE_W-1:0] early_line;
  logic [LINE_W-1:0] late_line;
  logic              consume;

  vrr_bounds #(.LINE_W(LINE_W), .GUARD_W(GUARD_W)) u_bounds (
    .vmin_m1       (vmin_m1),
    .vmax_m1       (vmax_m1),
    .flip_m1       (flip_m1),
    .guard         (guard),
    .flip_en       (flip_en),
    .ign_max_shift (ign_max_shift),
    .early_line    (early_line),
    .late_line     (late_line)
  );

  vrr_push_ctl u_push (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_wr (push_wr),
    .push_en (push_en),
    .live_en (live_en),
    .consume (consume),
    .pend_q  (push_pending)
  );

  vrr_line_fsm #(.LINE_W(LINE_W), .GUARD_W(GUARD_W)) u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .line_tick        (line_tick),
    .ctl_enable       (ctl_enable),
    .fix_vtotal       (fix_vtotal),
    .fix_vblank_start (fix_vblank_start),
    .early_line       (early_line),
    .late_line        (late_line),
    .guard            (guard),
    .pend             (push_pending),
    .consume          (consume),
    .line_q           (line_cnt),
    .frame_start_q    (frame_start),
    .latch_q          (latch_strobe),
    .live_q           (live_en)
  );
endmodule

// File: tb/vrr_vtiming_tb.sv
`timescale 1ns/1ps
module vrr_vtiming_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_tick = 1'b0;
  logic [15:0] fix_vtotal = 16'd20;
  logic [15:0] fix_vblank_start = 16'd12;
  logic [15:0] vmin_m1 = 16'd19;
  logic [15:0] vmax_m1 = 16'd39;
  logic [15:0] flip_m1 = 16'd20;
  logic [7:0]  guard = 8'd4;
  logic        ctl_enable = 1'b0;
  logic        ign_max_shift = 1'b1;
  logic        flip_en = 1'b1;
  logic        push_en = 1'b1;
  logic        push_wr = 1'b0;
  logic [15:0] line_cnt;
  logic        frame_start, latch_strobe, live_en, push_pending;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vrr_vtiming u_dut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
    .fix_vtotal(fix_vtotal), .fix_vblank_start(fix_vblank_start),
    .vmin_m1(vmin_m1), .vmax_m1(vmax_m1), .flip_m1(flip_m1), .guard(guard),
    .ctl_enable(ctl_enable), .ign_max_shift(ign_max_shift), .flip_en(flip_en),
    .push_en(push_en), .push_wr(push_wr),
    .line_cnt(line_cnt), .frame_start(frame_start), .latch_strobe(latch_strobe),
    .live_en(live_en), .push_pending(push_pending)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) line_tick = 1'b1;
    @(negedge clk) line_tick = 1'b0;
  endtask

  task automatic push();
    @(negedge clk) push_wr = 1'b1;
    @(negedge clk) push_wr = 1'b0;
  endtask

  // runs one frame from line 0; pushes when line_cnt equals pa or pb
  task automatic run_frame(input int pa, input int pb,
                           output int len, output int latch_at, output int pend_seen);
    len = 0; latch_at = -1; pend_seen = 0;
    for (int k = 0; k < 300; k++) begin
      if (line_cnt == pa || line_cnt == pb) begin
        push();
        pend_seen = push_pending;
      end
      tick();
      len++;
      if (latch_strobe) latch_at = line_cnt;
      if (frame_start) begin
        check("R11 line at frame start", line_cnt, 0);
        break;
      end
    end
  endtask

  task automatic t_reset();
    check("R12 line", line_cnt, 0);
    check("R12 live", live_en, 0);
    check("R12 pending", push_pending, 0);
    check("R12 strobes", frame_start | latch_strobe, 0);
  endtask

  task automatic t_fixed();
    int len, lat, ps;
    run_frame(-1, -1, len, lat, ps);
    check("R2 fixed length", len, 20);
    check("R2 fixed latch", lat, 12);
  endtask

  task automatic t_enable();
    int len, lat, ps;
    ctl_enable = 1'b1;
    push();
    check("R6 push while not live", push_pending, 0);
    check("R8 live held before wrap", live_en, 0);
    run_frame(-1, -1, len, lat, ps);
    check("R8 frame unchanged", len, 20);
    check("R8 live after wrap", live_en, 1);
  endtask

  task automatic t_nopush();
    int len, lat, ps;
    run_frame(-1, -1, len, lat, ps);
    check("R1 R3 no-push length", len, 40);
    check("R3 no-push latch", lat, 36);
  endtask

  task automatic t_window_push();
    int len, lat, ps;
    run_frame(25, -1, len, lat, ps);
    check("R7 pending readback", ps, 1);
    check("R4 window length", len, 30);
    check("R4 window latch", lat, 26);
    check("R7 pending cleared", push_pending, 0);
    run_frame(34, -1, len, lat, ps);
    check("R4 last-line length", len, 39);
    check("R4 last-line latch", lat, 35);
  endtask

  task automatic t_early_push();
    int len, lat, ps;
    run_frame(5, -1, len, lat, ps);
    check("R5 early length", len, 21);
    check("R5 early latch", lat, 17);
    run_frame(5, 8, len, lat, ps);
    check("R5 double push length", len, 21);
    run_frame(-1, -1, len, lat, ps);
    check("R5 nothing carried", len, 40);
  endtask

  task automatic t_unarmed();
    int len, lat, ps;
    push_en = 1'b0;
    run_frame(25, -1, len, lat, ps);
    check("R6 unarmed pending", ps, 0);
    check("R6 unarmed length", len, 40);
    push_en = 1'b1;
  endtask

  task automatic t_max_shift();
    int len, lat, ps;
    ign_max_shift = 1'b0;
    run_frame(-1, -1, len, lat, ps);
    check("R10 length", len, 44);
    check("R10 latch", lat, 40);
    ign_max_shift = 1'b1;
  endtask

  task automatic t_flip_off();
    int len, lat, ps;
    flip_en = 1'b0; vmin_m1 = 16'd17;
    run_frame(5, -1, len, lat, ps);
    check("R9 length", len, 19);
    check("R9 latch", lat, 15);
    flip_en = 1'b1; vmin_m1 = 16'd19;
  endtask

  task automatic t_disable();
    int len, lat, ps;
    ctl_enable = 1'b0;
    tick();
    check("R8 live held after clear", live_en, 1);
    run_frame(-1, -1, len, lat, ps);
    check("R8 finishing frame", len + 1, 40);
    check("R8 live cleared", live_en, 0);
    run_frame(-1, -1, len, lat, ps);
    check("R8 R2 back to fixed", len, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_enable();
    t_nopush();
    t_window_push();
    t_early_push();
    t_unarmed();
    t_max_shift();
    t_flip_off();
    t_disable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule